// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block takes a 64-bit device identifier that has already been recovered from a serial bus, one bit per strobe. It rebuilds the identifier in a register and runs an 8-bit CRC over the first 56 bits as they arrive. When the 64th bit lands, it compares the computed CRC with the top byte of the identifier. The result is a single-cycle completion pulse and a match flag that stays put.

A bus controller raises `start` once before each identifier. It then presents each received bit on `bit_in` with `bit_valid` high for one cycle. Bits travel least significant first. The CRC uses the polynomial x^8 + x^5 + x^4 + 1 in reflected form: the register shifts right, and 0x8C is XORed in whenever the feedback bit (CRC bit 0 XOR incoming bit) is 1. The stored byte is compared as it is, with no inversion. A second generator runs over all 64 bits, and its residue must be zero exactly when the identifier matches.

Top module: `serial_id_crc8_check`

## Requirements
- R1: After reset, `done` and `match` are 0, `crc_out` is 0x00 and `id_out` is all zeros. Bit strobes are ignored until the first `start`.
- R2: A `start` clears `crc_out` to 0x00, `id_out` to zero, `match` to 0 and the bit count. A bit strobe in the same cycle as `start` is dropped.
- R3: Accepted bits fill the identifier least significant first, so bit k of `id_out` is the k-th accepted bit, counting from 0.
- R4: After the 56th accepted bit, `crc_out` holds the reflected CRC-8 (shift right, XOR 0x8C on feedback, initial value 0x00) of those 56 bits.
- R5: Bits 57 to 64 do not change `crc_out`.
- R6: `done` is high for exactly one cycle. It rises on the clock edge that accepts the 64th bit.
- R7: `match` is 1 when `crc_out` equals `id_out[63:56]` with no inversion, and 0 otherwise. It is updated together with `done` and held until the next `start`.
- R8: Bit strobes after the 64th bit and before the next `start` change neither `id_out`, `crc_out`, `match` nor `done`.
- R9: Cycles with `bit_valid` low do not advance the capture. Gaps between bits have no effect on the result.
- R10: `match` is 1 exactly when the full 64 bits, stored CRC included, leave a zero residue in the generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a new identifier |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Received serial bit |
| done | output | 1 | One-cycle pulse after the 64th bit |
| match | output | 1 | Stored CRC equals the computed CRC |
| crc_out | output | 8 | Computed CRC over the 56 data bits |
| id_out | output | 64 | Captured identifier |

## Verification
A wrong bit count shows first as a `done` pulse that comes early, comes late or never comes. It can also show as an `id_out` whose bits sit at shifted positions, which is visible on the cycle after the shifted bit lands. A feedback tap error, or a CRC that keeps running into the stored byte, puts a wrong value on `crc_out` right after the 56th bit or during the last eight bits. Either fault also flips `match` against both the independently computed expectation and the full-word residue rule. A counter that does not saturate shows up as extra strobes changing `id_out` or bringing `done` back.

// File: rtl/serial_id_crc8_check.sv
module serial_id_crc8_check #(
  parameter int ID_W = 64,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h8C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             done,
  output logic             match,
  output logic [CRC_W-1:0] crc_out,
  output logic [ID_W-1:0]  id_out
);
  localparam int DATA_W = ID_W - CRC_W;
  localparam int CNT_W = $clog2(ID_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ID_W);
  localparam logic [CNT_W-1:0] DLIM = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] crc, res;
  logic [ID_W-1:0]  id;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic b);
    step = (c >> 1) ^ ((c[0] ^ b) ? POLY : '0);
  endfunction

  wire             take   = bit_valid && !start && (cnt != FULL);
  wire [ID_W-1:0]  id_nxt = {bit_in, id[ID_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= FULL;
      crc   <= '0;
      res   <= '0;
      id    <= '0;
      done  <= 1'b0;
      match <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt   <= '0;
        crc   <= '0;
        res   <= '0;
        id    <= '0;
        match <= 1'b0;
      end else if (take) begin
        cnt <= cnt + 1'b1;
        id  <= id_nxt;
        res <= step(res, bit_in);
        if (cnt < DLIM) crc <= step(crc, bit_in);
        if (cnt == FULL - 1'b1) begin
          done  <= 1'b1;
          match <= (crc == id_nxt[ID_W-1:DATA_W]);
        end
      end
    end
  end

  assign crc_out = crc;
  assign id_out  = id;

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (crc_out == '0 && id_out == '0 && !match && !done));
  p_crc_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt >= DLIM) |=> $stable(crc_out));
  p_ignore_extra_r8: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt == FULL) |=> ($stable(id_out) && $stable(match) && !done));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!start && !bit_valid) |=> ($stable(id_out) && $stable(crc_out)));
  p_residue_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (match == (res == '0)));
  p_match_cmp_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (match == (crc_out == id_out[ID_W-1:DATA_W])));
endmodule

// File: tb/serial_id_crc8_check_test.sv
module serial_id_crc8_check_test;
  logic clk = 0, rst = 1, start = 0, bit_valid = 0, bit_in = 0;
  logic done, match;
  logic [7:0] crc_out;
  logic [63:0] id_out;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  serial_id_crc8_check uut (.clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid),
    .bit_in(bit_in), .done(done), .match(match), .crc_out(crc_out), .id_out(id_out));

  function automatic logic [7:0] model_crc(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ v[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] with_crc(input logic [55:0] d);
    return {model_crc({8'h00, d}, 56), d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk); bit_valid = 1; bit_in = b;
    @(negedge clk); bit_valid = 0; bit_in = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_range(input logic [63:0] v, input int lo, input int hi, input int gap);
    for (int i = lo; i < hi; i++) send_bit(v[i], (gap > 0) ? (i % (gap + 1)) : 0);
  endtask

  task automatic send_full(input logic [63:0] v, input bit exp_match, input string req);
    do_start();
    send_range(v, 0, 63, 0);
    @(negedge clk); bit_valid = 1; bit_in = v[63];
    @(negedge clk); bit_valid = 0;
    chk(done === 1'b1, "R6", done, 1);
    chk(id_out === v, "R3", id_out, v);
    chk(match === exp_match, req, match, exp_match);
    @(negedge clk);
    chk(done === 1'b0, "R6", done, 0);
    chk(match === exp_match, "R7", match, exp_match);
  endtask

  task automatic t_reset();
    chk(done === 0 && match === 0, "R1", {done, match}, 0);
    chk(crc_out === 8'h00, "R1", crc_out, 0);
    chk(id_out === 64'h0, "R1", id_out, 0);
    send_range(64'hFFFF_FFFF_FFFF_FFFF, 0, 10, 0);
    chk(id_out === 64'h0 && crc_out === 0, "R1", id_out, 0);
  endtask

  task automatic t_known();
    logic [63:0] v = 64'hA200000001B81C02;
    send_full(v, 1, "R7");
    chk(crc_out === 8'hA2, "R4", crc_out, 8'hA2);
  endtask

  task automatic t_crc_stages();
    logic [63:0] v = with_crc(56'h3C_5A96_1E77_D4B1);
    logic [7:0] e = model_crc(v, 56);
    do_start();
    chk(crc_out === 0 && id_out === 0 && match === 0, "R2", crc_out, 0);
    send_range(v, 0, 56, 0);
    chk(crc_out === e, "R4", crc_out, e);
    send_range(v, 56, 64, 0);
    chk(crc_out === e, "R5", crc_out, e);
    chk(match === 1, "R10", match, 1);
  endtask

  task automatic t_bad();
    logic [63:0] g = with_crc(56'h12_3456_789A_BCDE);
    logic [63:0] inv = {~g[63:56], g[55:0]};
    send_full(inv, 0, "R7");
    send_full(g ^ 64'h0000_0100_0000_0000, 0, "R10");
    send_full(64'h0, 1, "R10");
  endtask

  task automatic t_extra();
    logic [63:0] v = with_crc(56'hFE_DCBA_9876_5432);
    send_full(v, 1, "R7");
    for (int i = 0; i < 5; i++) begin
      send_bit(i[0], 0);
      chk(done === 0, "R8", done, 0);
    end
    chk(id_out === v, "R8", id_out, v);
    chk(match === 1 && crc_out === v[63:56], "R8", {match, crc_out}, {1'b1, v[63:56]});
  endtask

  task automatic t_restart();
    logic [63:0] v = with_crc(56'h01_0203_0405_0607);
    do_start();
    send_range(64'hDEAD_BEEF_CAFE_F00D, 0, 30, 0);
    @(negedge clk); start = 1; bit_valid = 1; bit_in = 1;
    @(negedge clk); start = 0; bit_valid = 0; bit_in = 0;
    chk(id_out === 0 && crc_out === 0, "R2", id_out, 0);
    send_range(v, 0, 64, 0);
    chk(id_out === v && match === 1, "R2", id_out, v);
  endtask

  task automatic t_gaps();
    logic [63:0] v = with_crc(56'hA5_5AA5_5AA5_0FF0);
    do_start();
    send_range(v, 0, 64, 3);
    chk(id_out === v, "R9", id_out, v);
    chk(match === 1 && crc_out === v[63:56], "R9", crc_out, v[63:56]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_known();
    t_crc_stages();
    t_bad();
    t_extra();
    t_restart();
    t_gaps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule